// File: doc/BRIEF.md
# Exclusive-Access Reservation Monitor

This block sits between the load/store decode stage of a 32-bit processor and its data-memory port. It adds two operations: an exclusive word load and a conditional word store. An exclusive load reads a word and records the word address in a single reservation register. An exclusive store writes memory only when its word address equals the reservation. It reports the outcome on a carry-flag write port: carry 0 means the store was done, carry 1 means it was refused.

Every request arrives already decoded. It carries the instruction word, the effective address, the store data and a load/store direction. Memory strobes and the carry write are produced combinationally in the cycle the request is presented. The reservation register updates on the following clock edge. Each taken interrupt or exception is signalled by a one-cycle `trap_take` pulse, and that pulse drops the reservation. Ordinary loads and stores pass straight through and never touch the reservation or the carry flag.

Instruction fields used:
- The exclusive modifier is bit 10 and the byte-reverse modifier is bit 9.
- Bit 29 set marks the immediate form. In that form both modifiers are ignored.
- Bits 27:26 hold the size code: 0 is byte, 1 is halfword, 2 is word.

Top module: `lrsc_monitor`

## Requirements
- R1: When bit 29 of the instruction is 1 (immediate form), bit 10 has no effect. The access is treated as ordinary: no carry write, and the reservation is neither set nor tested.
- R2: For an exclusive access, `mem_addr` is `req_addr` with bits 1:0 forced to 0. No alignment fault is raised, whatever the low address bits are.
- R3: An exclusive load issues a read (`mem_req`=1, `mem_we`=0) at the aligned address. In the same cycle it writes carry 0. From the next cycle on, the reservation holds that aligned address.
- R4: An exclusive store whose aligned address equals the reservation writes carry 0 and issues the write (`mem_req`=1, `mem_we`=1). The reservation is kept.
- R5: An exclusive store whose aligned address differs from the reservation writes carry 1 and raises neither `mem_req` nor `mem_we`.
- R6: After reset no reservation is held (all-ones value), so the first exclusive store fails. With no request present, `mem_req`, `cf_we` and `align_fault` are 0.
- R7: A `trap_take` pulse clears the reservation from the next cycle on. The clear wins over an exclusive load presented in the same cycle, although that load still reads memory and writes carry 0.
- R8: Ordinary loads and stores pass address and data unchanged to memory. They raise no carry write and leave the reservation as it was.
- R9: An ordinary access whose address is not a multiple of its size (1 << size code bytes) raises `align_fault` and no memory strobe.
- R10: `mem_rev` follows bit 9 for register-register forms and is 0 for immediate forms.
- R11: An exclusive access always has word size (`mem_size` = 2), whatever the size code in the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_take | input | 1 | Interrupt or exception taken this cycle |
| req_valid | input | 1 | Decoded load/store request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_insn | input | 32 | Instruction word |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (aligned for exclusive) |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Access size code (log2 bytes) |
| mem_rev | output | 1 | Byte-reverse request to the memory side |
| align_fault | output | 1 | Unaligned ordinary access detected |
| cf_we | output | 1 | Carry flag write enable |
| cf_val | output | 1 | Carry flag value to write |

## Verification
A single ordered vector sequence drives the monitor through several patterns:
- A store with no reservation, which shows the reset sentinel never matches.
- A reserve followed by matching stores at different byte offsets of the same word, which separates alignment forcing from a plain address compare.
- A store to another word, and a store after a trap pulse. Each of these fails, and the absence of any memory strobe separates a refused store from a carry-only error.
- Ordinary stores and immediate-form loads carrying the exclusive bit, placed between a reservation and its store. These show that non-exclusive traffic neither consumes nor replaces the reservation.
- A trap in the same cycle as an exclusive load, which shows that the clear has priority.

Separate directed steps cover reset in the middle of a run, store data pass-through, and a byte-sized exclusive access that is forced to word size.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   // size code of a full word access (log2 of bytes)
   localparam logic [1:0] SZC_WORD = 2'd2;

   typedef struct packed {
      logic       excl;   // exclusive modifier honoured
      logic       rev;    // byte-reverse modifier honoured
      logic       imm;    // immediate form
      logic [1:0] szc;    // effective size code after forcing
   } dec_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
   import lrsc_pkg::*;
#(
   parameter int IW       = 32,
   parameter int AW       = 32,
   parameter int EXCL_BIT = 10,
   parameter int REV_BIT  = 9,
   parameter int IMM_BIT  = 29,
   parameter int SZ_LSB   = 26
) (
   input  logic [IW-1:0] insn,
   input  logic [AW-1:0] addr,
   output dec_t          dec,
   output logic [AW-1:0] eff_addr,
   output logic          misal
);
   localparam int WOFF  = int'(SZC_WORD);   // byte offset bits within a word
   localparam int LOW_W = 3;                // offset bits examined for size codes 0..3

   generate
      if (EXCL_BIT >= IW || REV_BIT >= IW || IMM_BIT >= IW || SZ_LSB + 1 >= IW) begin : g_bad_pos
         $error("lrsc_decode: instruction field position outside word");
      end
      if (AW <= LOW_W) begin : g_bad_aw
         $error("lrsc_decode: address width too small");
      end
   endgenerate

   logic       imm_form;
   logic [1:0] raw_szc;
   logic [1:0] acc_szc;
   logic       excl;
   logic [LOW_W-1:0] off_mask;

   assign imm_form = insn[IMM_BIT];
   assign raw_szc  = insn[SZ_LSB +: 2];
   assign excl     = !imm_form && insn[EXCL_BIT];
   assign acc_szc  = excl ? SZC_WORD : raw_szc;

   // one mask bit per offset bit: set when the access spans beyond it
   generate
      for (genvar i = 0; i < LOW_W; i++) begin : g_mask
         assign off_mask[i] = (int'(acc_szc) > i);
      end
   endgenerate

   always_comb begin
      dec.excl = excl;
      dec.rev  = !imm_form && insn[REV_BIT];
      dec.imm  = imm_form;
      dec.szc  = acc_szc;
      eff_addr = addr;
      if (excl) eff_addr[WOFF-1:0] = '0;
      misal    = !excl && |(addr[LOW_W-1:0] & off_mask);
   end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
   parameter int AW           = 32,
   parameter bit EXPLICIT_GRD = 1'b1   // 1: guard compare against the empty sentinel
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set,
   input  logic [AW-1:0] set_addr,
   input  logic [AW-1:0] cmp_addr,
   output logic          match
);
   localparam logic [AW-1:0] EMPTY = '1;

   logic [AW-1:0] resv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   resv_q <= EMPTY;
      else if (clr) resv_q <= EMPTY;
      else if (set) resv_q <= set_addr;
   end

   generate
      if (EXPLICIT_GRD) begin : g_guard
         assign match = (resv_q != EMPTY) && (resv_q == cmp_addr);
      end else begin : g_plain
         // aligned addresses never equal the all-ones sentinel
         assign match = (resv_q == cmp_addr);
      end
   endgenerate

   // R7
   trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (resv_q == EMPTY));

   // R3
   resv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !clr) |=> (resv_q == $past(set_addr)));

endmodule

// File: rtl/lrsc_gate.sv
module lrsc_gate #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          store,
   input  logic          excl,
   input  logic          misal,
   input  logic          match,
   input  logic [AW-1:0] eff_addr,
   input  logic [DW-1:0] wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          cf_we,
   output logic          cf_val
);
   logic refused;

   assign refused   = valid && store && excl && !match;
   assign mem_req   = valid && !misal && !refused;
   assign mem_we    = mem_req && store;
   assign mem_addr  = eff_addr;
   assign mem_wdata = wdata;
   assign cf_we     = valid && excl;
   assign cf_val    = store && !match;

   // R5
   fail_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_we && cf_val) |-> (!mem_req && !mem_we));

   // R4
   pass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_we && !cf_val && store) |-> mem_we);

   // R9
   fault_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && misal) |-> !mem_req);

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
   import lrsc_pkg::*;
#(
   parameter int IW       = 32,
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int EXCL_BIT = 10,
   parameter int REV_BIT  = 9,
   parameter int IMM_BIT  = 29,
   parameter int SZ_LSB   = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trap_take,
   input  logic          req_valid,
   input  logic          req_store,
   input  logic [IW-1:0] req_insn,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [1:0]    mem_size,
   output logic          mem_rev,
   output logic          align_fault,
   output logic          cf_we,
   output logic          cf_val
);
   generate
      if (DW != 8 * (1 << int'(SZC_WORD))) begin : g_bad_dw
         $error("lrsc_monitor: data width must match the word size code");
      end
   endgenerate

   dec_t          dec;
   logic [AW-1:0] eff_addr;
   logic          misal;
   logic          match;
   logic          resv_set;

   lrsc_decode #(
      .IW(IW), .AW(AW), .EXCL_BIT(EXCL_BIT), .REV_BIT(REV_BIT),
      .IMM_BIT(IMM_BIT), .SZ_LSB(SZ_LSB)
   ) u_dec (
      .insn     (req_insn),
      .addr     (req_addr),
      .dec      (dec),
      .eff_addr (eff_addr),
      .misal    (misal)
   );

   assign resv_set = req_valid && !req_store && dec.excl;

   lrsc_resv #(.AW(AW)) u_resv (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (trap_take),
      .set      (resv_set),
      .set_addr (eff_addr),
      .cmp_addr (eff_addr),
      .match    (match)
   );

   lrsc_gate #(.AW(AW), .DW(DW)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (req_valid),
      .store     (req_store),
      .excl      (dec.excl),
      .misal     (misal),
      .match     (match),
      .eff_addr  (eff_addr),
      .wdata     (req_wdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .cf_we     (cf_we),
      .cf_val    (cf_val)
   );

   assign mem_size    = dec.szc;
   assign mem_rev     = dec.rev;
   assign align_fault = req_valid && misal;

   // R2
   excl_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && cf_we) |-> (mem_addr[1:0] == 2'b00 && !align_fault));

   // R11
   excl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cf_we |-> (mem_size == SZC_WORD));

   // R8
   plain_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !cf_we) |-> (mem_addr == req_addr));

endmodule

// File: tb/sim_lrsc_monitor.sv
`timescale 1ns/1ps
module sim_lrsc_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_take = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [31:0] req_insn = '0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_we, mem_rev, align_fault, cf_we, cf_val;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0]  mem_size;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lrsc_monitor u0 (
      .clk(clk), .rst_n(rst_n), .trap_take(trap_take),
      .req_valid(req_valid), .req_store(req_store), .req_insn(req_insn),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rev(mem_rev),
      .align_fault(align_fault), .cf_we(cf_we), .cf_val(cf_val)
   );

   // instruction: [29]=immediate form, [27:26]=size code, [10]=exclusive, [9]=reverse
   function automatic logic [31:0] mk(bit imm, logic [1:0] sz, bit ex, bit rv);
      return {2'b11, imm, 1'b0, sz, 15'b0, ex, rv, 9'b0};
   endfunction

   localparam logic [31:0] I_XW   = mk(0, 2, 1, 0);
   localparam logic [31:0] I_XWR  = mk(0, 2, 1, 1);
   localparam logic [31:0] I_XB   = mk(0, 0, 1, 0);
   localparam logic [31:0] I_W    = mk(0, 2, 0, 0);
   localparam logic [31:0] I_H    = mk(0, 1, 0, 0);
   localparam logic [31:0] I_BR   = mk(0, 0, 0, 1);
   localparam logic [31:0] I_IMMX = mk(1, 2, 1, 0);
   localparam logic [31:0] I_IMMR = mk(1, 2, 0, 1);

   typedef struct packed {
      logic [3:0]  rq;
      logic        trap, vld, st;
      logic [31:0] insn, addr;
      logic        e_req, e_we;
      logic [31:0] e_addr;
      logic [1:0]  e_sz;
      logic        e_rev, e_cfwe, e_cfv, e_flt;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{4'd6,  1'b0,1'b1,1'b1, I_XW,  32'h100, 1'b0,1'b0, 32'h100, 2'd2, 1'b0,1'b1,1'b1,1'b0}, // R6 empty after reset
      '{4'd3,  1'b0,1'b1,1'b0, I_XW,  32'h102, 1'b1,1'b0, 32'h100, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R3 reserve
      '{4'd4,  1'b0,1'b1,1'b1, I_XW,  32'h103, 1'b1,1'b1, 32'h100, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R4 match
      '{4'd4,  1'b0,1'b1,1'b1, I_XW,  32'h100, 1'b1,1'b1, 32'h100, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R4 kept
      '{4'd5,  1'b0,1'b1,1'b1, I_XW,  32'h200, 1'b0,1'b0, 32'h200, 2'd2, 1'b0,1'b1,1'b1,1'b0}, // R5 other word
      '{4'd8,  1'b0,1'b1,1'b1, I_W,   32'h300, 1'b1,1'b1, 32'h300, 2'd2, 1'b0,1'b0,1'b0,1'b0}, // R8 plain store
      '{4'd8,  1'b0,1'b1,1'b1, I_XW,  32'h101, 1'b1,1'b1, 32'h100, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R8 resv intact
      '{4'd1,  1'b0,1'b1,1'b0, I_IMMX,32'h400, 1'b1,1'b0, 32'h400, 2'd2, 1'b0,1'b0,1'b0,1'b0}, // R1 imm ignores bit
      '{4'd1,  1'b0,1'b1,1'b1, I_XW,  32'h100, 1'b1,1'b1, 32'h100, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R1 resv unchanged
      '{4'd7,  1'b1,1'b0,1'b0, I_W,   32'h0,   1'b0,1'b0, 32'h0,   2'd2, 1'b0,1'b0,1'b0,1'b0}, // R7 trap pulse
      '{4'd7,  1'b0,1'b1,1'b1, I_XW,  32'h100, 1'b0,1'b0, 32'h100, 2'd2, 1'b0,1'b1,1'b1,1'b0}, // R7 store fails
      '{4'd7,  1'b1,1'b1,1'b0, I_XW,  32'h500, 1'b1,1'b0, 32'h500, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R7 trap + reserve
      '{4'd7,  1'b0,1'b1,1'b1, I_XW,  32'h500, 1'b0,1'b0, 32'h500, 2'd2, 1'b0,1'b1,1'b1,1'b0}, // R7 trap won
      '{4'd9,  1'b0,1'b1,1'b0, I_H,   32'h601, 1'b0,1'b0, 32'h601, 2'd1, 1'b0,1'b0,1'b0,1'b1}, // R9 misaligned half
      '{4'd10, 1'b0,1'b1,1'b0, I_BR,  32'h603, 1'b1,1'b0, 32'h603, 2'd0, 1'b1,1'b0,1'b0,1'b0}, // R10 reverse byte
      '{4'd11, 1'b0,1'b1,1'b0, I_XB,  32'h7FF, 1'b1,1'b0, 32'h7FC, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R11 forced word
      '{4'd2,  1'b0,1'b1,1'b1, I_XW,  32'h7FE, 1'b1,1'b1, 32'h7FC, 2'd2, 1'b0,1'b1,1'b0,1'b0}, // R2 offset 2
      '{4'd10, 1'b0,1'b1,1'b1, I_XWR, 32'h7FD, 1'b1,1'b1, 32'h7FC, 2'd2, 1'b1,1'b1,1'b0,1'b0}, // R10 excl+rev
      '{4'd10, 1'b0,1'b1,1'b0, I_IMMR,32'h404, 1'b1,1'b0, 32'h404, 2'd2, 1'b0,1'b0,1'b0,1'b0}  // R10 imm no rev
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(bit tr, bit v, bit s, logic [31:0] ins, logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      trap_take = tr; req_valid = v; req_store = s;
      req_insn = ins; req_addr = a; req_wdata = d;
      #1;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      // R6 reset state
      repeat (2) @(negedge clk);
      #1;
      check("R6 mem_req in reset", 32'(mem_req), 32'd0);
      check("R6 cf_we in reset", 32'(cf_we), 32'd0);
      check("R6 align_fault in reset", 32'(align_fault), 32'd0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string t;
         drive(TBL[i].trap, TBL[i].vld, TBL[i].st, TBL[i].insn, TBL[i].addr, 32'h1234_0000 + 32'(i));
         t = $sformatf("R%0d v%0d", TBL[i].rq, i);
         check({t, " mem_req"}, 32'(mem_req), 32'(TBL[i].e_req));
         check({t, " mem_we"}, 32'(mem_we), 32'(TBL[i].e_we));
         check({t, " cf_we"}, 32'(cf_we), 32'(TBL[i].e_cfwe));
         if (TBL[i].e_cfwe) check({t, " cf_val"}, 32'(cf_val), 32'(TBL[i].e_cfv));
         check({t, " align_fault"}, 32'(align_fault), 32'(TBL[i].e_flt));
         if (TBL[i].vld) begin
            check({t, " mem_addr"}, mem_addr, TBL[i].e_addr);
            check({t, " mem_size"}, 32'(mem_size), 32'(TBL[i].e_sz));
            check({t, " mem_rev"}, 32'(mem_rev), 32'(TBL[i].e_rev));
         end
      end

      // R8 store data passes unchanged
      drive(0, 1, 1, I_W, 32'h0000_0A00, 32'hA5A5_0F0F);
      check("R8 mem_wdata", mem_wdata, 32'hA5A5_0F0F);
      check("R8 plain store we", 32'(mem_we), 32'd1);

      // R6 reset in mid-run drops a held reservation
      drive(0, 1, 0, I_XW, 32'h0000_0900, 32'h0);
      drive(0, 0, 0, I_W, 32'h0, 32'h0);
      rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      drive(0, 1, 1, I_XW, 32'h0000_0900, 32'h5);
      check("R6 store after reset cf_val", 32'(cf_val), 32'd1);
      check("R6 store after reset mem_req", 32'(mem_req), 32'd0);

      // R3 reserve again and confirm with a store
      drive(0, 1, 0, I_XW, 32'h0000_0901, 32'h0);
      drive(0, 1, 1, I_XW, 32'h0000_0902, 32'h6);
      check("R3 store after reserve cf_val", 32'(cf_val), 32'd0);
      check("R3 store after reserve mem_we", 32'(mem_we), 32'd1);

      drive(0, 0, 0, I_W, 32'h0, 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule